// File: doc/BRIEF.md
# Dual-Bank Read-While-Write Flash Controller

This block is a synchronous behavioural model and controller for a 16-bit word-wide flash store split into two banks. The banks share one request port, one data path and one response path. The most significant word-address bit selects the bank. The remaining bits give the word offset inside that bank. Sector and block indices are taken from the offset bits above `SECT_W` and `BLK_W`.

Each bank runs its own internal program or erase cycle, and the length of each cycle is set by a parameter. While one bank is in such a cycle, reads of the other bank are served as normal. A read that hits the busy bank returns a status word in place of array data. The status word carries a toggle bit and a polled complement of the data being written. Device-ID reads are locked out while either bank is busy. A low-power flag is set once a completed read is left idle, and it drops on any new request or address change without slowing the next access.

The storage array is a scaled-down register model; by default each bank holds 64 words. Operation codes on `op` are: 0 read, 1 program, 2 sector erase, 3 block erase, 4 ID read. Codes 5 to 7 do nothing.

Top module: `dual_bank_flash`

## Requirements
- R1: Address bit `ADDR_W-1` selects the bank (0 or 1), and the lower `ADDR_W-1` bits select a word inside it. The two banks hold separate data, so a word written at offset k in one bank leaves offset k of the other bank unchanged.
- R2: After reset every word of both banks reads 16'hFFFF, and `busy`, `rvalid`, `err` and `low_power` are all 0.
- R3: Program (op 1) can only clear bits. The stored word becomes the old word ANDed with `wdata`, and the new value can be read once the bank is idle.
- R4: A read (op 0) of a bank that is not busy sets `rvalid` and returns the stored word on `rdata` one cycle after the request. This also holds while the other bank is busy.
- R5: A read (op 0) of a busy bank returns a status word. Bit 7 is the inverse of bit 7 of the pending data, and the pending data is 16'hFFFF for an erase. Bit 6 is 0 on the first status read after the operation starts and flips on each later status read of that bank. All other bits are 0.
- R6: A program or erase request (op 1, 2 or 3) to a bank that is busy is ignored. It raises `err` for exactly one cycle and does not change the array.
- R7: An ID read (op 4) returns `DEV_ID` when both banks are idle. While any bank is busy, it returns that bank's status word instead (bank 0 if both are busy).
- R8: Sector erase (op 2) sets to 16'hFFFF every word in the addressed bank whose offset bits above `SECT_W` match the request. All other words are left untouched.
- R9: Block erase (op 3) sets to 16'hFFFF every word in the addressed bank whose offset bits above `BLK_W` match the request. All other words are left untouched.
- R10: An accepted program or erase raises `busy` for its bank on the accepting edge and loads a counter with `PROG_CYC` or `ERASE_CYC`. `busy` clears on the edge after the counter reaches zero, so it stays high for N+1 cycles.
- R11: `low_power` rises on the edge after a cycle with `rvalid`, provided no request is made and the address is unchanged. It falls on the edge after any request or address change. A read made while `low_power` is 1 still answers in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per operation |
| op | input | 3 | Operation code |
| addr | input | ADDR_W | Word address, top bit selects the bank |
| wdata | input | 16 | Program data |
| rdata | output | 16 | Read, status or ID word |
| rvalid | output | 1 | `rdata` valid this cycle |
| busy | output | 2 | Per-bank busy flags |
| err | output | 1 | One-cycle pulse for a rejected program or erase |
| low_power | output | 1 | Automatic low-power flag |

## Verification
The assertions assume that `req`, `op` and `addr` are held at defined values during reset, so that the first `$past` sample after reset is meaningful. They also assume that `DEV_ID` cannot be mistaken for a status word. The bench drives `req` low throughout reset and changes every input only on the falling edge. Each operation is a single-cycle strobe, and after a program or erase the bench waits a fixed count derived from the cycle parameters, so every idle-bank read falls after the busy flag has cleared. Overlapping requests are issued deliberately, and only where the rejection, status and ID-lockout paths are under test.

// File: rtl/dual_bank_flash.sv
module dual_bank_flash #(
  parameter int ADDR_W    = 7,
  parameter int SECT_W    = 2,
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 6,
  parameter logic [15:0] DEV_ID = 16'h2D15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              rvalid,
  output logic [1:0]        busy,
  output logic              err,
  output logic              low_power
);
  localparam int OFF_W = ADDR_W - 1;
  localparam int DEPTH = 1 << OFF_W;
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [2:0] OP_READ = 3'd0;
  localparam logic [2:0] OP_PROG = 3'd1;
  localparam logic [2:0] OP_ESEC = 3'd2;
  localparam logic [2:0] OP_EBLK = 3'd3;
  localparam logic [2:0] OP_ID   = 3'd4;

  logic [15:0]       mem  [2][DEPTH];
  logic [CNT_W-1:0]  cnt  [2];
  logic [2:0]        kind [2];
  logic [OFF_W-1:0]  padr [2];
  logic [15:0]       pdat [2];
  logic [1:0]        tog;
  logic [ADDR_W-1:0] addr_q;

  wire             bsel  = addr[ADDR_W-1];
  wire [OFF_W-1:0] off   = addr[OFF_W-1:0];
  wire             wr_op = (op == OP_PROG) || (op == OP_ESEC) || (op == OP_EBLK);

  function automatic logic [15:0] stat(input logic [15:0] d, input logic t);
    return {8'h00, ~d[7], t, 6'h00};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      tog       <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
      err       <= 1'b0;
      low_power <= 1'b0;
      addr_q    <= '0;
      for (int b = 0; b < 2; b++) begin
        cnt[b]  <= '0;
        kind[b] <= OP_PROG;
        padr[b] <= '0;
        pdat[b] <= '1;
        for (int i = 0; i < DEPTH; i++) mem[b][i] <= '1;
      end
    end else begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      addr_q <= addr;
      if (req || addr != addr_q) low_power <= 1'b0;
      else if (rvalid)           low_power <= 1'b1;

      for (int b = 0; b < 2; b++) begin
        if (busy[b]) begin
          if (cnt[b] != '0) cnt[b] <= cnt[b] - 1'b1;
          else begin
            busy[b] <= 1'b0;
            case (kind[b])
              OP_PROG: mem[b][padr[b]] <= mem[b][padr[b]] & pdat[b];
              OP_ESEC:
                for (int i = 0; i < DEPTH; i++)
                  if ((OFF_W'(i) >> SECT_W) == (padr[b] >> SECT_W)) mem[b][i] <= '1;
              default:
                for (int i = 0; i < DEPTH; i++)
                  if ((OFF_W'(i) >> BLK_W) == (padr[b] >> BLK_W)) mem[b][i] <= '1;
            endcase
          end
        end
      end

      if (req) begin
        case (op)
          OP_READ: begin
            rvalid <= 1'b1;
            if (busy[bsel]) begin
              rdata     <= stat(pdat[bsel], tog[bsel]);
              tog[bsel] <= ~tog[bsel];
            end else rdata <= mem[bsel][off];
          end
          OP_ID: begin
            rvalid <= 1'b1;
            if (busy[0]) begin
              rdata  <= stat(pdat[0], tog[0]);
              tog[0] <= ~tog[0];
            end else if (busy[1]) begin
              rdata  <= stat(pdat[1], tog[1]);
              tog[1] <= ~tog[1];
            end else rdata <= DEV_ID;
          end
          OP_PROG, OP_ESEC, OP_EBLK: begin
            if (busy[bsel]) err <= 1'b1;
            else begin
              busy[bsel] <= 1'b1;
              tog[bsel]  <= 1'b0;
              kind[bsel] <= op;
              padr[bsel] <= off;
              pdat[bsel] <= (op == OP_PROG) ? wdata : 16'hFFFF;
              cnt[bsel]  <= (op == OP_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_busy_req_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr_op && busy[bsel]) |=> err);
  assert_err_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(req) && $past(busy) != 2'b00));
  assert_idle_req_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr_op && !busy[bsel]) |=> (busy[$past(bsel)] && !err));
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy[0] && cnt[0] != '0) |=> busy[0]);
  assert_read_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (op == OP_READ || op == OP_ID)) |=> rvalid);
  assert_id_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == OP_ID && busy != 2'b00) |=> (rdata != DEV_ID));
  assert_lp_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !low_power);
endmodule

// File: tb/dual_bank_flash_test.sv
module dual_bank_flash_test;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 3;
  localparam int ECYC = 6;
  localparam logic [15:0] ID = 16'h2D15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] op = 3'd0;
  logic [6:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid, err, low_power;
  logic [1:0] busy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  dual_bank_flash uut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .busy(busy), .err(err), .low_power(low_power)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [6:0] a, input logic [15:0] d);
    op = o; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [38:0] VEC [4] = '{
    {7'h05, 16'h5A3C, 16'h5A3C},
    {7'h45, 16'hC3A5, 16'hC3A5},
    {7'h05, 16'h00FF, 16'h003C},
    {7'h7F, 16'h0001, 16'h0001}
  };

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 busy", {14'd0, busy}, 16'd0);
    check("R2 rvalid", {15'd0, rvalid}, 16'd0);
    check("R2 err", {15'd0, err}, 16'd0);
    check("R2 low_power", {15'd0, low_power}, 16'd0);
    issue(3'd0, 7'h33, 16'h0);
    check("R2 erased word", rdata, 16'hFFFF);

    for (int v = 0; v < 4; v++) begin
      issue(3'd1, VEC[v][38:32], VEC[v][31:16]);
      idle(PCYC + 2);
      issue(3'd0, VEC[v][38:32], 16'h0);
      check("R3 program/readback", rdata, VEC[v][15:0]);
    end
    issue(3'd0, 7'h45, 16'h0);
    check("R1 bank1 offset5 separate", rdata, 16'hC3A5);
    issue(3'd0, 7'h3F, 16'h0);
    check("R1 bank0 offset3F untouched", rdata, 16'hFFFF);

    issue(3'd1, 7'h08, 16'h0080);
    issue(3'd0, 7'h08, 16'h0);
    check("R5 status first", rdata, 16'h0000);
    issue(3'd0, 7'h09, 16'h0);
    check("R5 status toggled", rdata, 16'h0040);
    issue(3'd0, 7'h45, 16'h0);
    check("R4 rvalid during other busy", {15'd0, rvalid}, 16'd1);
    check("R4 read other bank", rdata, 16'hC3A5);
    check("R10 still busy", {14'd0, busy}, 16'd1);
    @(negedge clk);
    check("R10 cleared", {14'd0, busy}, 16'd0);
    issue(3'd0, 7'h08, 16'h0);
    check("R3 status data committed", rdata, 16'h0080);

    issue(3'd1, 7'h09, 16'h1111);
    issue(3'd1, 7'h09, 16'h0000);
    check("R6 err pulse", {15'd0, err}, 16'd1);
    @(negedge clk);
    check("R6 err one cycle", {15'd0, err}, 16'd0);
    idle(PCYC + 2);
    issue(3'd0, 7'h09, 16'h0);
    check("R6 rejected program ignored", rdata, 16'h1111);

    issue(3'd4, 7'h00, 16'h0);
    check("R7 ID idle", rdata, ID);
    issue(3'd1, 7'h48, 16'hFF00);
    issue(3'd4, 7'h00, 16'h0);
    check("R7 ID locked status", rdata, 16'h0080);
    idle(PCYC + 2);
    issue(3'd0, 7'h48, 16'h0);
    check("R3 bank1 program", rdata, 16'hFF00);

    issue(3'd1, 7'h10, 16'h1234); idle(PCYC + 2);
    issue(3'd1, 7'h14, 16'h5678); idle(PCYC + 2);
    issue(3'd1, 7'h20, 16'h9ABC); idle(PCYC + 2);
    issue(3'd2, 7'h11, 16'h0);
    check("R10 erase busy", {14'd0, busy}, 16'd1);
    issue(3'd0, 7'h12, 16'h0);
    check("R5 erase status", rdata, 16'h0000);
    idle(ECYC - 1);
    check("R10 erase busy at count end", {14'd0, busy}, 16'd1);
    @(negedge clk);
    check("R10 erase cleared", {14'd0, busy}, 16'd0);
    issue(3'd0, 7'h10, 16'h0);
    check("R8 sector erased", rdata, 16'hFFFF);
    issue(3'd0, 7'h14, 16'h0);
    check("R8 next sector kept", rdata, 16'h5678);
    issue(3'd3, 7'h1F, 16'h0); idle(ECYC + 2);
    issue(3'd0, 7'h14, 16'h0);
    check("R9 block erased", rdata, 16'hFFFF);
    issue(3'd0, 7'h20, 16'h0);
    check("R9 next block kept", rdata, 16'h9ABC);
    issue(3'd0, 7'h48, 16'h0);
    check("R9 other bank kept", rdata, 16'hFF00);

    issue(3'd0, 7'h05, 16'h0);
    check("R11 low_power off on read", {15'd0, low_power}, 16'd0);
    @(negedge clk);
    check("R11 low_power entered", {15'd0, low_power}, 16'd1);
    issue(3'd0, 7'h45, 16'h0);
    check("R11 read from low power data", rdata, 16'hC3A5);
    check("R11 low_power exit on req", {15'd0, low_power}, 16'd0);
    @(negedge clk);
    check("R11 low_power re-entered", {15'd0, low_power}, 16'd1);
    addr = 7'h46;
    @(negedge clk);
    check("R11 low_power exit on addr", {15'd0, low_power}, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule